// File: doc/BRIEF.md
# Snapshot-Read Interval Timer

This block is a 16-bit down-counting interval timer driven through a narrow byte register port. Software stages a reload count one byte at a time, then writes a start register. That write copies the staged count into the running counter and arms it. Once armed, the counter steps down by one on every cycle that the `tick` input is high. At the end of each period it reloads from the staged count and raises a one-cycle `zero_pulse`, so the pulse rate is the tick rate divided by the staged count. For example, a 2 MHz tick with a staged count of 20000 gives 100 pulses per second.

Software never reads the running counter directly. A capture command copies the counter into a snapshot register. Reads at the two count offsets then return the snapshot bytes, and writes at those same offsets go to the staging bytes. Clock division and interrupt routing sit outside this block.

Top module: `ivt_top`

## Requirements
- R1: After reset the staged count, running counter and snapshot are all zero, `zero_pulse` is low, and reads at offsets 0x0 and 0x4 return 0x00.
- R2: A write to offset 0x0 sets staged bits 7:0 and a write to offset 0x4 sets staged bits 15:8. Neither write changes the running counter or the snapshot.
- R3: Any write to offset 0x8 copies the staged count into the running counter on that clock edge and arms the counter, whatever the data byte is.
- R4: A write of 0x01 to offset 0xC copies the counter value held before that edge into the snapshot.
- R5: A write to offset 0xC with any data other than 0x01 has no effect, and the snapshot keeps its value until the next valid capture.
- R6: Reads are combinational. Offset 0x0 returns snapshot bits 7:0, offset 0x4 returns bits 15:8, and every other offset returns 0x00.
- R7: While armed, a tick on a counter value above 1 decrements it by one. A tick on a value of 1 or 0 reloads the staged count and drives `zero_pulse` high for the following cycle. With a staged count of N the pulse therefore comes every N ticks, and every tick when N is 0 or 1.
- R8: A start write on the same edge as a reloading tick takes priority. The staged count is loaded and no pulse is raised.
- R9: Ticks before the first start write leave the counter at zero and raise no pulse.
- R10: A reload uses the staged count present at the time of the reload, so restaging while the counter runs changes only later periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Count enable, one step per high cycle |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| zero_pulse | output | 1 | One-cycle pulse after each reload |

## Verification
Some properties are checked on every cycle:
- A start write loads the staged value.
- A valid capture copies the counter, and the snapshot stays still otherwise.
- A tick on an armed counter above 1 decrements it.
- Every pulse traces back to an armed tick that no start write overrode.
- An unarmed counter neither moves nor pulses.

Other behaviour only the bench scenarios can show, because it needs whole sequences observed through the read port. This covers pulse periods for several staged counts including 0 and 1, the byte placement of read-back values, restaging during a run, and the collision of a start write with a reload.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
    // Byte lane width of the register port.
    localparam int LANE_W = 8;
    // Spacing between register offsets, in bytes.
    localparam int STRIDE = 4;
    // Data value that makes a capture write valid.
    localparam logic [LANE_W-1:0] CAPTURE_KEY = 8'h01;

    // Offset of the start register, which follows the staging lanes.
    function automatic int go_offset(input int nbytes);
        return STRIDE * nbytes;
    endfunction

    // Offset of the capture register, which follows the start register.
    function automatic int cap_offset(input int nbytes);
        return STRIDE * nbytes + STRIDE;
    endfunction
endpackage

// File: rtl/ivt_decode.sv
// Register-port write decoder.
// Turns one write into a per-lane staging enable, a start strobe or a
// capture strobe. A capture strobe is raised only when the data byte equals
// the capture key. Offsets that match no register produce no strobe.
// Assumes at most one write per cycle.
module ivt_decode
    import ivt_pkg::*;
#(
    parameter int NBYTES = 2,
    parameter int ADDR_W = 4
) (
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [LANE_W-1:0] bus_wdata,
    output logic [NBYTES-1:0] lane_we,
    output logic              go_stb,
    output logic              cap_stb
);
    localparam logic [ADDR_W-1:0] GO_ADDR  = ADDR_W'(go_offset(NBYTES));
    localparam logic [ADDR_W-1:0] CAP_ADDR = ADDR_W'(cap_offset(NBYTES));

    genvar i;
    generate
        for (i = 0; i < NBYTES; i++) begin : g_lane
            // Enable for staging lane i.
            assign lane_we[i] = bus_wr && (bus_addr == ADDR_W'(STRIDE * i));
        end
    endgenerate

    // Start strobe; the data byte is ignored.
    assign go_stb  = bus_wr && (bus_addr == GO_ADDR);
    // Capture strobe; only the key value counts.
    assign cap_stb = bus_wr && (bus_addr == CAP_ADDR) && (bus_wdata == CAPTURE_KEY);
endmodule

// File: rtl/ivt_stage.sv
// Staging register for the reload count, written one byte lane at a time.
// Its value is used both by a start write and by each periodic reload.
// Assumes CNT_W is NBYTES * LANE_W.
module ivt_stage
    import ivt_pkg::*;
#(
    parameter int NBYTES = 2,
    localparam int CNT_W = NBYTES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NBYTES-1:0] lane_we,
    input  logic [LANE_W-1:0] wdata,
    output logic [CNT_W-1:0]  stage_q
);
    genvar i;
    generate
        for (i = 0; i < NBYTES; i++) begin : g_byte
            // Hold one staged byte; cleared by reset.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    stage_q[i*LANE_W +: LANE_W] <= '0;
                else if (lane_we[i])
                    stage_q[i*LANE_W +: LANE_W] <= wdata;
            end
        end
    endgenerate
endmodule

// File: rtl/ivt_counter.sv
// Running down-counter with auto-reload.
// Stays idle until the first start strobe. Once armed, each tick steps the
// count down. A tick on a count of 1 or 0 reloads from the staged value and
// raises a registered pulse for the next cycle. A start strobe overrides a
// tick on the same edge.
module ivt_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             go_stb,
    input  logic [CNT_W-1:0] stage_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic             armed_q,
    output logic             zero_pulse
);
    logic at_end;

    // End of period: the next tick would reach zero, or the count is already there.
    assign at_end = (cnt_q <= CNT_W'(1));

    // Update the count, the armed flag and the reload pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            armed_q    <= 1'b0;
            zero_pulse <= 1'b0;
        end else begin
            zero_pulse <= 1'b0;
            if (go_stb) begin
                cnt_q   <= stage_q;
                armed_q <= 1'b1;
            end else if (armed_q && tick) begin
                if (at_end) begin
                    cnt_q      <= stage_q;
                    zero_pulse <= 1'b1;
                end else begin
                    cnt_q <= cnt_q - CNT_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/ivt_snapshot.sv
// Snapshot register and read-back multiplexer.
// A capture strobe copies the running count. Reads at the staging lane
// offsets return the matching snapshot byte; all other offsets read zero.
// Assumes a combinational read path.
module ivt_snapshot
    import ivt_pkg::*;
#(
    parameter int NBYTES = 2,
    parameter int ADDR_W = 4,
    localparam int CNT_W = NBYTES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_stb,
    input  logic [CNT_W-1:0]  cnt_q,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic [CNT_W-1:0]  snap_q,
    output logic [LANE_W-1:0] bus_rdata
);
    logic [NBYTES-1:0][LANE_W-1:0] lane_rd;

    // Capture the running count on command.
    always_ff @(posedge clk) begin
        if (!rst_n)
            snap_q <= '0;
        else if (cap_stb)
            snap_q <= cnt_q;
    end

    genvar i;
    generate
        for (i = 0; i < NBYTES; i++) begin : g_rd
            // Gate snapshot byte i onto the read path when its offset is selected.
            assign lane_rd[i] = (bus_addr == ADDR_W'(STRIDE * i)) ?
                                snap_q[i*LANE_W +: LANE_W] : '0;
        end
    endgenerate

    // OR the gated lanes together; at most one lane is non-zero.
    always_comb begin
        bus_rdata = '0;
        for (int k = 0; k < NBYTES; k++)
            bus_rdata = bus_rdata | lane_rd[k];
    end
endmodule

// File: rtl/ivt_top.sv
// Snapshot-read interval timer, top level.
// Connects the write decoder, the staging register, the running counter and
// the snapshot path. Assumes CNT_W is a whole number of bytes.
module ivt_top
    import ivt_pkg::*;
#(
    parameter int CNT_W = 16,
    localparam int NBYTES = CNT_W / LANE_W,
    localparam int ADDR_W = $clog2(STRIDE * NBYTES + 2 * STRIDE)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [LANE_W-1:0] bus_wdata,
    output logic [LANE_W-1:0] bus_rdata,
    output logic              zero_pulse
);
    logic [NBYTES-1:0] lane_we;
    logic              go_stb;
    logic              cap_stb;
    logic [CNT_W-1:0]  stage_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  snap_q;
    logic              armed_q;

    ivt_decode #(.NBYTES(NBYTES), .ADDR_W(ADDR_W)) u_dec (
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .lane_we   (lane_we),
        .go_stb    (go_stb),
        .cap_stb   (cap_stb)
    );

    ivt_stage #(.NBYTES(NBYTES)) u_stage (
        .clk     (clk),
        .rst_n   (rst_n),
        .lane_we (lane_we),
        .wdata   (bus_wdata),
        .stage_q (stage_q)
    );

    ivt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .go_stb     (go_stb),
        .stage_q    (stage_q),
        .cnt_q      (cnt_q),
        .armed_q    (armed_q),
        .zero_pulse (zero_pulse)
    );

    ivt_snapshot #(.NBYTES(NBYTES), .ADDR_W(ADDR_W)) u_snap (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_stb   (cap_stb),
        .cnt_q     (cnt_q),
        .bus_addr  (bus_addr),
        .snap_q    (snap_q),
        .bus_rdata (bus_rdata)
    );
endmodule

// File: rtl/ivt_chk.sv
// Cycle-level property checker for ivt_top, attached by bind.
// Observes strobes, counter state and the snapshot; drives nothing.
module ivt_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             go_stb,
    input logic             cap_stb,
    input logic             armed_q,
    input logic             zero_pulse,
    input logic [CNT_W-1:0] stage_q,
    input logic [CNT_W-1:0] cnt_q,
    input logic [CNT_W-1:0] snap_q
);
    // R3: a start write loads the staged count and arms the counter.
    a_r3_go_loads: assert property (@(posedge clk) disable iff (!rst_n)
        go_stb |=> (cnt_q == $past(stage_q)) && armed_q);

    // R4: a valid capture copies the pre-edge count.
    a_r4_capture_copies: assert property (@(posedge clk) disable iff (!rst_n)
        cap_stb |=> snap_q == $past(cnt_q));

    // R5: without a valid capture the snapshot stays put.
    a_r5_snap_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_stb |=> $stable(snap_q));

    // R7: an armed tick above 1 decrements by one.
    a_r7_decrement: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && tick && !go_stb && cnt_q > CNT_W'(1)) |=> cnt_q == $past(cnt_q) - CNT_W'(1));

    // R7/R8: every pulse follows an armed tick that no start write overrode.
    a_r8_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
        zero_pulse |-> ($past(tick) && $past(armed_q) && !$past(go_stb)));

    // R9: an idle counter neither moves nor pulses.
    a_r9_idle_still: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed_q && !go_stb) |=> ($stable(cnt_q) && !zero_pulse));
endmodule

bind ivt_top ivt_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .go_stb     (go_stb),
    .cap_stb    (cap_stb),
    .armed_q    (armed_q),
    .zero_pulse (zero_pulse),
    .stage_q    (stage_q),
    .cnt_q      (cnt_q),
    .snap_q     (snap_q)
);

// File: tb/sim_ivt_top.sv
module sim_ivt_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       bus_wr = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       zero_pulse;

    int n_checks = 0;
    int n_errors = 0;

    // Table entries: {staged count, number of ticks}.
    localparam logic [31:0] VEC [8] = '{
        {16'd5, 16'd3}, {16'd5, 16'd5}, {16'd5, 16'd12}, {16'd1, 16'd4},
        {16'd0, 16'd3}, {16'h1234, 16'd7}, {16'hABCD, 16'd2}, {16'd2, 16'd9}
    };

    ivt_top u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .zero_pulse(zero_pulse)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic stage16(input logic [15:0] v);
        wr(4'h0, v[7:0]);
        wr(4'h4, v[15:8]);
    endtask

    // Capture, then read both snapshot bytes.
    task automatic snap16(output logic [15:0] v);
        logic [7:0] lo, hi;
        wr(4'hC, 8'h01);
        rd(4'h0, lo);
        rd(4'h4, hi);
        v = {hi, lo};
    endtask

    // Apply n single-cycle ticks; count pulses seen in the following cycles.
    task automatic ticks(input int n, inout int pulses);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
            if (zero_pulse) pulses++;
        end
    endtask

    // Requirement model: final count and number of reloads.
    function automatic logic [31:0] model(input logic [15:0] n, input int k);
        logic [15:0] c = n;
        logic [15:0] p = 0;
        for (int i = 0; i < k; i++) begin
            if (c <= 16'd1) begin c = n; p++; end
            else c--;
        end
        return {p, c};
    endfunction

    initial begin
        #2_000_000;
        n_checks++;
        n_errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        logic [7:0]  b;
        logic [15:0] v;
        logic [31:0] m;
        int p;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: state after reset.
        rd(4'h0, b); check("R1 lo", b, 0);
        rd(4'h4, b); check("R1 hi", b, 0);
        check("R1 pulse", zero_pulse, 0);

        // R2, R9: staging only, ticks while idle.
        stage16(16'h1234);
        p = 0; ticks(5, p);
        check("R9 no pulse idle", p, 0);
        snap16(v); check("R2 staging leaves counter", v, 16'h0000);

        // R3: start write with arbitrary data.
        wr(4'h8, 8'hA5);
        snap16(v); check("R3 go loads", v, 16'h1234);

        // R5: non-key capture is ignored.
        p = 0; ticks(2, p);
        wr(4'hC, 8'h02);
        rd(4'h0, b); check("R5 lo hold", b, 8'h34);
        rd(4'h4, b); check("R5 hi hold", b, 8'h12);
        // R4: valid capture.
        snap16(v); check("R4 capture", v, 16'h1232);

        // R6: other offsets read zero.
        rd(4'h8, b); check("R6 go reads 0", b, 0);
        rd(4'hC, b); check("R6 cap reads 0", b, 0);
        rd(4'h2, b); check("R6 gap reads 0", b, 0);

        // R7: table of staged counts and tick counts.
        for (int i = 0; i < 8; i++) begin
            stage16(VEC[i][31:16]);
            wr(4'h8, 8'h00);
            p = 0; ticks(int'(VEC[i][15:0]), p);
            m = model(VEC[i][31:16], int'(VEC[i][15:0]));
            snap16(v);
            check($sformatf("R7 count vec%0d", i), v, m[15:0]);
            check($sformatf("R7 pulses vec%0d", i), p, m[31:16]);
        end

        // R10: restage while running; the reload takes the new value.
        stage16(16'd4); wr(4'h8, 8'h00);
        stage16(16'd9);
        p = 0; ticks(4, p);
        check("R10 pulse", p, 1);
        snap16(v); check("R10 new reload", v, 16'd9);

        // R8: start write collides with a reloading tick.
        stage16(16'd3); wr(4'h8, 8'h00);
        p = 0; ticks(2, p);
        stage16(16'd7);
        @(negedge clk);
        tick = 1'b1; bus_wr = 1'b1; bus_addr = 4'h8;
        @(negedge clk);
        tick = 1'b0; bus_wr = 1'b0;
        check("R8 no pulse", zero_pulse, 0);
        snap16(v); check("R8 staged loaded", v, 16'd7);

        // R1: reset clears everything again.
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        snap16(v); check("R1 after reset", v, 0);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule